// File: doc/BRIEF.md
# Byte/Word Integer ALU with Status Flags

This block is the execute stage for a small family of integer operations on 8-bit or 16-bit operands: subtract, compare, bitwise AND, OR and XOR, and two's-complement negate. Each accepted operation produces a result, a destination write-enable and six status flags: carry (CF), parity (PF), auxiliary carry (AF), zero (ZF), sign (SF) and overflow (OF). The flags follow the usual rules for this style of machine. Compare behaves as a subtract whose result is not stored. The logical operations force the carry, overflow and auxiliary flags low. Negate is a subtract of the operand from zero.

An upstream stage presents two operands, an opcode and a width select together with a valid strobe. Everything is registered once. One clock later the result, the write-enable and the flags appear with a one-cycle output valid pulse, and they hold their values until the next accepted operation. Fetching operands, decoding instructions, checking operand legality and acting on the flags are left to the surrounding pipeline.

Top module: `alu86_core`

## Requirements
- R1: An operation accepted on a clock edge where `in_valid` is 1 shows its result, write-enable and flags after that edge, with `out_valid` high for exactly that one cycle. The outputs hold their values while no new operation is accepted. Synchronous reset drives every output to 0.
- R2: Opcode 0 (subtract) returns A minus B within the selected width with `out_wr_en` = 1. CF is the unsigned borrow. OF is 1 when A and B have different signs and the result's sign differs from A's sign.
- R3: Opcode 1 (compare) gives the same result and the same six flags as opcode 0 on the same inputs, but with `out_wr_en` = 0.
- R4: Opcodes 2, 3 and 4 return A AND B, A OR B and A XOR B within the selected width, with `out_wr_en` = 1.
- R5: For opcodes 2, 3 and 4, CF, OF and AF are all 0.
- R6: Opcode 5 (negate) ignores B and returns zero minus A with `out_wr_en` = 1. CF is 1 unless A is zero. OF is 1 only when A is the most negative value for the width (0x80 for a byte, 0x8000 for a word).
- R7: For opcodes 0, 1 and 5, AF is the borrow out of bit 3 of the subtraction.
- R8: PF is 1 when bits 7..0 of the result hold an even number of ones, in both widths.
- R9: ZF is 1 when the result is zero within the selected width. SF is bit 7 of the result in byte mode and bit 15 in word mode.
- R10: With `in_word` = 0, only bits 7..0 of each operand are used and result bits 15..8 are 0.
- R11: Opcodes 6 and 7 are reserved. They produce a zero result, all flags 0 and `out_wr_en` = 0, while still pulsing `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Opcode: 0 sub, 1 cmp, 2 and, 3 or, 4 xor, 5 neg |
| in_word | input | 1 | 1 = 16-bit operands, 0 = 8-bit operands |
| in_a | input | 16 | First operand (destination value) |
| in_b | input | 16 | Second operand (source value) |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_result | output | 16 | Result, zero-extended in byte mode |
| out_wr_en | output | 1 | Destination should be written |
| out_cf | output | 1 | Carry / borrow flag |
| out_pf | output | 1 | Parity flag |
| out_af | output | 1 | Auxiliary carry flag |
| out_zf | output | 1 | Zero flag |
| out_sf | output | 1 | Sign flag |
| out_of | output | 1 | Overflow flag |

## Verification
The output-valid assertion compares `out_valid` with the previous cycle's `in_valid`. It therefore assumes `in_valid` is held low during reset, and the stimulus keeps it low for the whole reset period. The per-opcode assertions read the opcode and width from the previous cycle and assume these inputs are meaningful whenever `in_valid` is high. The stimulus mixes directed corner operands with random ones, inserts idle cycles between operations, places unrelated data in the upper operand byte during byte operations, and sends random B values to negate so that R6's independence from B is observed at the outputs.

// File: rtl/alu86_pkg.sv
package alu86_pkg;
  typedef enum logic [2:0] {
    OP_SUB = 3'd0,
    OP_CMP = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_NEG = 3'd5,
    OP_RS6 = 3'd6,
    OP_RS7 = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } alu_flags_t;
endpackage

// File: rtl/alu86_arith.sv
module alu86_arith #(
  parameter int DW = 16,
  parameter int BW = 8,
  parameter int NW = 4
) (
  input  logic          is_neg,
  input  logic          word,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res,
  output logic          borrow,
  output logic          half_borrow,
  output logic          ovf
);
  localparam int UW = DW - BW;

  logic [DW-1:0] am, bm, x, y;
  logic [DW:0]   diff;
  logic [NW:0]   nib;
  logic          sx, sy, sr;

  always_comb begin
    am   = word ? a : {{UW{1'b0}}, a[BW-1:0]};
    bm   = word ? b : {{UW{1'b0}}, b[BW-1:0]};
    x    = is_neg ? '0 : am;
    y    = is_neg ? am : bm;
    diff = {1'b0, x} - {1'b0, y};
    nib  = {1'b0, x[NW-1:0]} - {1'b0, y[NW-1:0]};
    res  = word ? diff[DW-1:0] : {{UW{1'b0}}, diff[BW-1:0]};
    borrow      = word ? diff[DW] : diff[BW];
    half_borrow = nib[NW];
    sx   = word ? x[DW-1] : x[BW-1];
    sy   = word ? y[DW-1] : y[BW-1];
    sr   = word ? diff[DW-1] : diff[BW-1];
    ovf  = (sx != sy) && (sr != sx);
  end
endmodule

// File: rtl/alu86_logic.sv
module alu86_logic #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic [1:0]    sel,
  input  logic          word,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res
);
  localparam int UW = DW - BW;

  logic [DW-1:0] raw;

  always_comb begin
    unique case (sel)
      2'd0:    raw = a & b;
      2'd1:    raw = a | b;
      default: raw = a ^ b;
    endcase
    res = word ? raw : {{UW{1'b0}}, raw[BW-1:0]};
  end
endmodule

// File: rtl/alu86_resflags.sv
module alu86_resflags #(
  parameter int DW = 16,
  parameter int BW = 8,
  parameter int PW = 8
) (
  input  logic          word,
  input  logic [DW-1:0] res,
  output logic          pf,
  output logic          zf,
  output logic          sf
);
  always_comb begin
    pf = ~^res[PW-1:0];
    zf = word ? (res == '0) : (res[BW-1:0] == '0);
    sf = word ? res[DW-1] : res[BW-1];
  end
endmodule

// File: rtl/alu86_core.sv
module alu86_core #(
  parameter int DW = 16,
  parameter int BW = 8,
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [2:0]    in_op,
  input  logic          in_word,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  output logic          out_valid,
  output logic [DW-1:0] out_result,
  output logic          out_wr_en,
  output logic          out_cf,
  output logic          out_pf,
  output logic          out_af,
  output logic          out_zf,
  output logic          out_sf,
  output logic          out_of
);
  import alu86_pkg::*;

  alu_op_e       op;
  logic [DW-1:0] ar_res, lg_res, nx_res;
  logic          ar_cf, ar_af, ar_of;
  logic          rf_pf, rf_zf, rf_sf;
  logic [1:0]    lg_sel;
  logic          is_arith, is_logic, nx_wr;
  alu_flags_t    nx_fl, fl_q;

  assign op       = alu_op_e'(in_op);
  assign is_arith = (op == OP_SUB) || (op == OP_CMP) || (op == OP_NEG);
  assign is_logic = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign lg_sel   = in_op[1:0] - 2'd2;

  alu86_arith #(.DW(DW), .BW(BW), .NW(NW)) arith_i (
    .is_neg      (op == OP_NEG),
    .word        (in_word),
    .a           (in_a),
    .b           (in_b),
    .res         (ar_res),
    .borrow      (ar_cf),
    .half_borrow (ar_af),
    .ovf         (ar_of)
  );

  alu86_logic #(.DW(DW), .BW(BW)) logic_i (
    .sel  (lg_sel),
    .word (in_word),
    .a    (in_a),
    .b    (in_b),
    .res  (lg_res)
  );

  always_comb begin
    nx_res = '0;
    if (is_arith)      nx_res = ar_res;
    else if (is_logic) nx_res = lg_res;
  end

  alu86_resflags #(.DW(DW), .BW(BW), .PW(BW)) rflags_i (
    .word (in_word),
    .res  (nx_res),
    .pf   (rf_pf),
    .zf   (rf_zf),
    .sf   (rf_sf)
  );

  always_comb begin
    nx_fl = '0;
    nx_wr = 1'b0;
    if (is_arith || is_logic) begin
      nx_fl.pf = rf_pf;
      nx_fl.zf = rf_zf;
      nx_fl.sf = rf_sf;
      nx_wr    = (op != OP_CMP);
    end
    if (is_arith) begin
      nx_fl.cf = ar_cf;
      nx_fl.af = ar_af;
      nx_fl.of = ar_of;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_wr_en  <= 1'b0;
      fl_q       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result <= nx_res;
        out_wr_en  <= nx_wr;
        fl_q       <= nx_fl;
      end
    end
  end

  assign out_cf = fl_q.cf;
  assign out_pf = fl_q.pf;
  assign out_af = fl_q.af;
  assign out_zf = fl_q.zf;
  assign out_sf = fl_q.sf;
  assign out_of = fl_q.of;
endmodule

// File: rtl/alu86_checks.sv
module alu86_checks #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    in_op,
  input logic          in_word,
  input logic          out_valid,
  input logic [DW-1:0] out_result,
  input logic          out_wr_en,
  input logic          out_cf,
  input logic          out_pf,
  input logic          out_af,
  input logic          out_zf,
  input logic          out_of
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  assert_held_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result) && $stable(out_wr_en));

  assert_cmp_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_op == 3'd1 |=> !out_wr_en);

  assert_logic_clear_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_op == 3'd2 || in_op == 3'd3 || in_op == 3'd4)
      |=> !out_cf && !out_of && !out_af);

  assert_parity_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_pf == ($countones(out_result[7:0]) % 2 == 0) ||
                  (out_result == '0 && !out_zf));

  assert_zero_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_wr_en |-> out_zf == (out_result == '0));

  assert_byte_upper_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_word |=> out_result[DW-1:BW] == '0);

  assert_reserved_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_op[2:1] == 2'b11 |=> !out_wr_en && out_result == '0 && !out_zf);
endmodule

bind alu86_core alu86_checks #(.DW(DW), .BW(BW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .in_word    (in_word),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_wr_en  (out_wr_en),
  .out_cf     (out_cf),
  .out_pf     (out_pf),
  .out_af     (out_af),
  .out_zf     (out_zf),
  .out_of     (out_of)
);

// File: tb/alu86_core_tb_top.sv
module alu86_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_op = '0;
  logic          in_word = 1'b0;
  logic [DW-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic          out_valid, out_wr_en;
  logic [DW-1:0] out_result;
  logic          out_cf, out_pf, out_af, out_zf, out_sf, out_of;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic          e_valid = 0, e_wr = 0;
  logic [DW-1:0] e_res = '0;
  logic          e_cf = 0, e_pf = 0, e_af = 0, e_zf = 0, e_sf = 0, e_of = 0;
  int            e_op = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu86_core dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_word(in_word),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result),
    .out_wr_en(out_wr_en), .out_cf(out_cf), .out_pf(out_pf), .out_af(out_af),
    .out_zf(out_zf), .out_sf(out_sf), .out_of(out_of)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference: integers only
  task automatic model(input int op, input bit word, input int a, input int b);
    int w, mask, am, bm, x, y, r, ones;
    w = word ? 16 : 8;
    mask = (1 << w) - 1;
    am = a & mask;
    bm = b & mask;
    e_op = op;
    e_cf = 0; e_af = 0; e_of = 0; e_wr = 0; r = 0;
    if (op == 0 || op == 1 || op == 5) begin
      x = (op == 5) ? 0 : am;
      y = (op == 5) ? am : bm;
      r = (x - y) & mask;
      e_cf = (x < y);
      e_af = ((x & 15) < (y & 15));
      e_of = (((x >> (w-1)) & 1) != ((y >> (w-1)) & 1)) &&
             (((r >> (w-1)) & 1) != ((x >> (w-1)) & 1));
      e_wr = (op != 1);
    end else if (op == 2 || op == 3 || op == 4) begin
      r = (op == 2) ? (am & bm) : (op == 3) ? (am | bm) : (am ^ bm);
      e_wr = 1;
    end
    e_res = r[DW-1:0];
    if (op <= 5) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      e_pf = (ones % 2 == 0);
      e_zf = (r == 0);
      e_sf = (r >> (w-1)) & 1;
    end else begin
      e_pf = 0; e_zf = 0; e_sf = 0;
    end
  endtask

  function automatic string tag_res(input int op);
    if (op == 0) return "R2";
    if (op == 1) return "R3";
    if (op == 5) return "R6";
    if (op >= 6) return "R11";
    return "R4";
  endfunction

  task automatic compare_all();
    string tr, tc;
    tr = tag_res(e_op);
    tc = (e_op >= 2 && e_op <= 4) ? "R5" : tr;
    chk("R1", "out_valid", int'(out_valid), int'(e_valid));
    chk(tr, "result", int'(out_result), int'(e_res));
    chk(tr, "wr_en", int'(out_wr_en), int'(e_wr));
    chk(tc, "cf", int'(out_cf), int'(e_cf));
    chk(tc, "of", int'(out_of), int'(e_of));
    chk((e_op >= 2 && e_op <= 4) ? "R5" : "R7", "af", int'(out_af), int'(e_af));
    chk("R8", "pf", int'(out_pf), int'(e_pf));
    chk("R9", "zf", int'(out_zf), int'(e_zf));
    chk("R9", "sf", int'(out_sf), int'(e_sf));
  endtask

  // one cycle: check previous outcome, then drive the next input
  task automatic step(input bit v, input int op, input bit word, input int a, input int b);
    @(negedge clk);
    compare_all();
    in_valid = v;
    in_op    = op[2:0];
    in_word  = word;
    in_a     = a[DW-1:0];
    in_b     = b[DW-1:0];
    e_valid  = v;
    if (v) model(op, word, a, b);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state (R1)
    step(0, 0, 0, 0, 0);
    // R2 subtract corners
    step(1, 0, 0, 16'hAB00, 16'h0001);   // byte 0-1: borrow, AF, R10 upper ignored
    step(1, 0, 1, 16'h8000, 16'h0001);   // word overflow
    step(1, 0, 1, 16'h1234, 16'h1234);   // zero
    step(0, 0, 0, 16'hFFFF, 16'hFFFF);   // idle: R1 hold
    step(0, 3, 1, 16'h0F0F, 16'h1111);
    // R3 compare
    step(1, 1, 0, 16'h007F, 16'h00FF);
    step(1, 1, 1, 16'h0010, 16'h0008);
    // R4/R5 logic
    step(1, 2, 1, 16'hF0F0, 16'hFF00);
    step(1, 3, 0, 16'h5A12, 16'h3C81);
    step(1, 4, 1, 16'hAAAA, 16'hAAAA);
    step(1, 4, 0, 16'h12F0, 16'h340F);
    // R6 negate, B ignored
    step(1, 5, 0, 16'h0000, 16'h1234);
    step(1, 5, 0, 16'h0080, 16'hFFFF);
    step(1, 5, 1, 16'h8000, 16'h0001);
    step(1, 5, 1, 16'h0001, 16'h7777);
    // R11 reserved
    step(1, 6, 1, 16'h1234, 16'h0001);
    step(1, 7, 0, 16'h0000, 16'h0000);
    for (int k = 0; k < 600; k++)
      step(($urandom % 4) != 0, $urandom % 8, $urandom % 2, $urandom, $urandom);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 50000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule